// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a stereo serial audio stream (bit clock, word-select and data lines) into parallel 24-bit left and right samples. All three serial inputs are brought into the system clock domain through synchronizer flops. The system clock must run well above the bit clock. A rising edge of the synchronized bit clock samples the word-select and data lines. Each change of the sampled word-select level starts a new channel half-frame. The block counts bit slots inside a half-frame and assembles the word.

A 3-bit format code selects the framing. There are two MSB-first positional framings, one with a one-slot delay and one with none. There is also an LSB-anchored framing at four word lengths. Positional words are MSB-aligned to 24 bits. LSB-anchored words are sign-extended to 24 bits. Once a frame's right channel has ended, the block presents both samples together with a one-cycle valid strobe.

Top module: `aud_ser_rx`

## Requirements
- R1: While rst_ni is low, and after it is released until the first frame completes, left_o and right_o are zero and valid_o is low.
- R2: Format code 000 (delayed-MSB framing): the left channel occupies word-select low. The MSB is in the second bit slot after a word-select change (slot 1). The next 24 slots fill bits 23 down to 0. Slot 0 and slots after the 24th are ignored.
- R3: Format codes 001 and 111 give results identical to code 000 for the same stream.
- R4: Format code 010 (no-delay framing): the left channel occupies word-select high. The MSB is in slot 0, the first slot after the change, and slots 0 to 23 fill bits 23 down to 0. Later slots are ignored.
- R5: Format codes 011, 100, 110 and 101 select LSB-anchored framing with 24, 20, 18 and 16 bit words. The left channel occupies word-select high and each channel has 32 slots. The LSB is in the last slot before the word-select change. The word is sign-extended to 24 bits, and slots ahead of the word are ignored.
- R6: For codes 000, 001, 111 and 010, bit positions that a half-frame is too short to reach read as zero.
- R7: valid_o is a single-cycle pulse, issued once per frame when the right half-frame ends (at the next word-select change). left_o and right_o update only with that pulse and hold otherwise.
- R8: No valid_o pulse is issued until a complete left half-frame and a complete right half-frame have followed the first word-select change after reset. A half-frame cut short by reset is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversampling the bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial bit clock, asynchronous |
| lrck_i | input | 1 | Word-select (channel) line, asynchronous |
| sdin_i | input | 1 | Serial data, two's complement, MSB first |
| fmt_i | input | 3 | Framing format code, held static while running |
| left_o | output | 24 | Left sample of the last complete frame |
| right_o | output | 24 | Right sample of the last complete frame |
| valid_o | output | 1 | One-cycle strobe when both samples update |

## Verification
Each framing is driven with words that pair a full-scale negative value with a positive or mixed-bit value. Every slot the framing must ignore is filled with ones, so a one-slot offset error or capture of a stray slot changes the result. All eight format codes are run. The LSB-anchored codes are run with negative samples, which tell proper sign extension apart from zero fill, and each code is identified by the length of the word it recovers. A 16-slot half-frame in the no-delay framing exercises the zero fill of unreached LSBs. The priming half-frame after each reset must produce no strobe.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int LEN_W    = $clog2(SAMPLE_W + 1);

  typedef enum logic [1:0] {FR_DLY, FR_NODLY, FR_LSB} frame_e;

  typedef struct packed {
    frame_e           kind;
    logic [LEN_W-1:0] len;
  } fmt_t;

  function automatic fmt_t fmt_decode(input logic [2:0] code);
    fmt_t f;
    f.kind = FR_DLY;
    f.len  = LEN_W'(SAMPLE_W);
    case (code)
      3'b010: f.kind = FR_NODLY;
      3'b011: begin f.kind = FR_LSB; f.len = LEN_W'(24); end
      3'b100: begin f.kind = FR_LSB; f.len = LEN_W'(20); end
      3'b101: begin f.kind = FR_LSB; f.len = LEN_W'(16); end
      3'b110: begin f.kind = FR_LSB; f.len = LEN_W'(18); end
      default: f.kind = FR_DLY;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q[0] <= '0;
    else         st_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[g] <= '0;
      else         st_q[g] <= st_q[g-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/aud_rx_slot.sv
module aud_rx_slot #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             lrck_i,
  input  logic             sdin_i,
  output logic             bit_stb_o,
  output logic             new_half_o,
  output logic             bit_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             end_lr_o,
  output logic             armed_o
);
  localparam logic [CNT_W-1:0] IDX_MAX = '1;

  logic             sclk_d_q, lr_prev_q, armed_q;
  logic [CNT_W-1:0] idx_q, idx_n;
  logic             rise, new_half;

  assign rise     = sclk_i & ~sclk_d_q;
  assign new_half = rise & (lrck_i != lr_prev_q);

  always_comb begin
    if (new_half)              idx_n = '0;
    else if (idx_q == IDX_MAX) idx_n = IDX_MAX;
    else                       idx_n = idx_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q  <= 1'b0;
      lr_prev_q <= 1'b0;
      armed_q   <= 1'b0;
      idx_q     <= IDX_MAX;
    end else begin
      sclk_d_q <= sclk_i;
      if (rise) begin
        lr_prev_q <= lrck_i;
        idx_q     <= idx_n;
        if (new_half) armed_q <= 1'b1;
      end
    end
  end

  assign bit_stb_o  = rise;
  assign new_half_o = new_half;
  assign bit_o      = sdin_i;
  assign idx_o      = idx_n;
  assign end_lr_o   = lr_prev_q;
  assign armed_o    = armed_q;

  // R2
  idx_moves_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise |=> $stable(idx_q));
endmodule

// File: rtl/aud_rx_word.sv
module aud_rx_word
  import aud_rx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  fmt_t                fmt_i,
  input  logic                bit_stb_i,
  input  logic                new_half_i,
  input  logic                bit_i,
  input  logic [CNT_W-1:0]    idx_i,
  input  logic                end_lr_i,
  input  logic                armed_i,
  output logic                done_o,
  output logic                done_left_o,
  output logic [SAMPLE_W-1:0] word_o
);
  logic [SAMPLE_W-1:0] acc_q, acc_n, base;

  function automatic logic [SAMPLE_W-1:0] sext(input logic [SAMPLE_W-1:0] a,
                                               input logic [LEN_W-1:0]    n);
    logic [SAMPLE_W-1:0] r;
    for (int i = 0; i < SAMPLE_W; i++)
      r[i] = (i < int'(n)) ? a[i] : a[int'(n) - 1];
    return r;
  endfunction

  always_comb begin
    int off, k;
    off   = (fmt_i.kind == FR_DLY) ? 1 : 0;
    k     = int'(idx_i) - off;
    base  = new_half_i ? '0 : acc_q;
    acc_n = base;
    if (fmt_i.kind == FR_LSB) begin
      acc_n = {base[SAMPLE_W-2:0], bit_i};
    end else if (k >= 0 && k < SAMPLE_W) begin
      acc_n[SAMPLE_W-1-k] = bit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        acc_q <= '0;
    else if (bit_stb_i) acc_q <= acc_n;
  end

  // the word closes at the first slot of the next half-frame
  assign done_o      = bit_stb_i & new_half_i & armed_i;
  assign done_left_o = (fmt_i.kind == FR_DLY) ? ~end_lr_i : end_lr_i;
  assign word_o      = (fmt_i.kind == FR_LSB) ? sext(acc_q, fmt_i.len) : acc_q;
endmodule

// File: rtl/aud_ser_rx.sv
module aud_ser_rx
  import aud_rx_pkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sclk_i,
  input  logic                lrck_i,
  input  logic                sdin_i,
  input  logic [2:0]          fmt_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  logic [2:0]          sync_q;
  logic                bit_stb, new_half, bit_s, end_lr, armed;
  logic [CNT_W-1:0]    idx;
  logic                done, done_left;
  logic [SAMPLE_W-1:0] word;
  logic [SAMPLE_W-1:0] left_hold_q;
  logic                have_left_q;
  fmt_t                fmt;

  assign fmt = fmt_decode(fmt_i);

  aud_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, lrck_i, sdin_i}),
    .q_o   (sync_q)
  );

  aud_rx_slot #(.CNT_W(CNT_W)) u_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_i    (sync_q[2]),
    .lrck_i    (sync_q[1]),
    .sdin_i    (sync_q[0]),
    .bit_stb_o (bit_stb),
    .new_half_o(new_half),
    .bit_o     (bit_s),
    .idx_o     (idx),
    .end_lr_o  (end_lr),
    .armed_o   (armed)
  );

  aud_rx_word #(.CNT_W(CNT_W)) u_word (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fmt_i      (fmt),
    .bit_stb_i  (bit_stb),
    .new_half_i (new_half),
    .bit_i      (bit_s),
    .idx_i      (idx),
    .end_lr_i   (end_lr),
    .armed_i    (armed),
    .done_o     (done),
    .done_left_o(done_left),
    .word_o     (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_hold_q <= '0;
      have_left_q <= 1'b0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (done) begin
        if (done_left) begin
          left_hold_q <= word;
          have_left_q <= 1'b1;
        end else if (have_left_q) begin
          left_o      <= left_hold_q;
          right_o     <= word;
          valid_o     <= 1'b1;
          have_left_q <= 1'b0;
        end
      end
    end
  end

  // R7
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R7
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));
  // R8
  valid_after_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> armed);
endmodule

// File: tb/sim_aud_ser_rx.sv
module sim_aud_ser_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, lrck = 1'b0, sdin = 1'b0;
  logic [2:0]  fmt = 3'b000;
  logic [23:0] left_w, right_w;
  logic        valid_w;

  typedef struct {
    logic [23:0] l;
    logic [23:0] r;
    string       tag;
  } exp_t;

  exp_t  exp_q[$];
  int    checks = 0, errors = 0, vcount = 0;
  logic  vprev = 1'b0;
  logic [23:0] last_l = '0, last_r = '0;

  always #5 clk = ~clk;

  aud_ser_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .lrck_i(lrck), .sdin_i(sdin),
    .fmt_i(fmt), .left_o(left_w), .right_o(right_w), .valid_o(valid_w)
  );

  task automatic check(input bit ok, input string tag, input logic [23:0] act,
                       input logic [23:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && valid_w) begin
      vcount++;
      check(!vprev, "R7 single-cycle strobe", 24'(vprev), 24'd0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected strobe", left_w, 24'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(left_w == e.l, {e.tag, " left"}, left_w, e.l);
        check(right_w == e.r, {e.tag, " right"}, right_w, e.r);
        last_l = e.l;
        last_r = e.r;
      end
    end
    vprev = valid_w;
  end

  task automatic slot(input logic lr, input logic d);
    @(negedge clk);
    sclk = 1'b0; lrck = lr; sdin = d;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_half(input logic lr, input logic [63:0] s, input int n);
    for (int i = 0; i < n; i++) slot(lr, s[i]);
  endtask

  function automatic logic [63:0] mk_pos(input logic [23:0] w, input int off, input int n);
    logic [63:0] s = '1;
    for (int i = 0; i < n; i++) begin
      int k = i - off;
      if (k >= 0 && k < 24) s[i] = w[23-k];
    end
    return s;
  endfunction

  function automatic logic [23:0] exp_pos(input logic [23:0] w, input int off, input int n);
    logic [23:0] e = '0;
    for (int k = 0; k < 24; k++) if (k + off < n) e[23-k] = w[23-k];
    return e;
  endfunction

  function automatic logic [63:0] mk_lsb(input logic [23:0] w, input int wl);
    logic [63:0] s = '1;
    for (int i = 0; i < 32; i++) begin
      int j = 31 - i;
      if (j < wl) s[i] = w[j];
    end
    return s;
  endfunction

  function automatic logic [23:0] exp_lsb(input logic [23:0] w, input int wl);
    logic [23:0] e;
    for (int i = 0; i < 24; i++) e[i] = (i < wl) ? w[i] : w[wl-1];
    return e;
  endfunction

  function automatic logic left_lvl(input logic [2:0] c);
    return (c == 3'b000 || c == 3'b001 || c == 3'b111) ? 1'b0 : 1'b1;
  endfunction

  task automatic start_group(input logic [2:0] c);
    @(negedge clk);
    rst_n = 1'b0; sclk = 1'b0; lrck = 1'b0; sdin = 1'b0; fmt = c;
    repeat (3) @(negedge clk);
    check(left_w == 0 && right_w == 0 && !valid_w, "R1 reset state", left_w, 24'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(left_w == 0 && right_w == 0 && !valid_w, "R1 after release", left_w, 24'd0);
    vcount = 0;
    // priming half at the right-channel level
    send_half(~left_lvl(c), '1, 32);
  endtask

  task automatic end_group(input logic [2:0] c, input string tag);
    send_half(left_lvl(c), '1, 32);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, {tag, " R7 one strobe per frame"}, 24'(exp_q.size()), 24'd0);
    check(left_w == last_l && right_w == last_r, {tag, " R7 outputs held"}, left_w, last_l);
  endtask

  task automatic frame_pos(input logic [23:0] l, input logic [23:0] r, input int n,
                           input string tag);
    int   off = left_lvl(fmt) ? 0 : 1;
    exp_t e;
    e.l = exp_pos(l, off, n);
    e.r = exp_pos(r, off, n);
    e.tag = tag;
    exp_q.push_back(e);
    send_half(left_lvl(fmt), mk_pos(l, off, n), n);
    send_half(~left_lvl(fmt), mk_pos(r, off, n), n);
  endtask

  task automatic frame_lsb(input logic [23:0] l, input logic [23:0] r, input int wl,
                           input string tag);
    exp_t e;
    e.l = exp_lsb(l, wl);
    e.r = exp_lsb(r, wl);
    e.tag = tag;
    exp_q.push_back(e);
    send_half(1'b1, mk_lsb(l, wl), 32);
    send_half(1'b0, mk_lsb(r, wl), 32);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    // R2 delayed-MSB framing
    start_group(3'b000);
    frame_pos(24'h123456, 24'hABCDEF, 32, "R2 dly a");
    // R8: the priming half closed with no left word captured
    check(vcount == 0, "R8 no strobe after priming", 24'(vcount), 24'd0);
    frame_pos(24'h800000, 24'h7FFFFF, 32, "R2 dly b");
    end_group(3'b000, "R2");

    // R3 aliases
    start_group(3'b001);
    frame_pos(24'h5A0F3C, 24'hC3A501, 32, "R3 code 001");
    end_group(3'b001, "R3");
    start_group(3'b111);
    frame_pos(24'h0000FF, 24'hF00001, 32, "R3 code 111");
    end_group(3'b111, "R3");

    // R4 no-delay framing, R6 short half-frame
    start_group(3'b010);
    frame_pos(24'h9ABCDE, 24'h13579B, 32, "R4 nodly a");
    frame_pos(24'h800001, 24'h7FFFFE, 32, "R4 nodly b");
    frame_pos(24'hFEDCBA, 24'hA5A5A5, 16, "R6 short half");
    end_group(3'b010, "R4");

    // R5 LSB-anchored at each length
    start_group(3'b011);
    frame_lsb(24'h812345, 24'h7ABCDE, 24, "R5 len24");
    end_group(3'b011, "R5");
    start_group(3'b100);
    frame_lsb(24'h080001, 24'h012345, 20, "R5 len20");
    end_group(3'b100, "R5");
    start_group(3'b110);
    frame_lsb(24'h020003, 24'h01FFFF, 18, "R5 len18");
    end_group(3'b110, "R5");
    start_group(3'b101);
    frame_lsb(24'h008001, 24'h001234, 16, "R5 len16");
    frame_lsb(24'h00FFFF, 24'h007FFF, 16, "R5 len16 b");
    end_group(3'b101, "R5");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule